// File: doc/BRIEF.md
# Input-Voltage Flash Current Governor

This block sits beside the flash current ramp controller and watches a digitized supply-voltage sample, in millivolts, while a flash pulse is in progress. The governor compares the sample against a programmable down line and against an up line that sits a programmable hysteresis above it. When the supply sags below the down line it raises a one-cycle flag and starts a filter delay. If the sag persists beyond the delay, the governor acts on the LED current according to one of four policies. The report policy only flags. The stop-and-hold policy freezes the level for the rest of the pulse. The down-only policy trims the level one step per ramp step period. The up-and-down policy trims below the down line and restores toward the target above the up line.

The governor holds an internal ceiling, `cap`, which is reset to the target at the start of every flash. It presents `min(ramp level, cap)` as the level to drive. It also emits hold, decrement and increment strobes so the ramp controller can follow. When the function is disabled or no flash is active, the ramp level passes through unchanged and no strobe fires.

The control is one state machine:
- IDLE: the function is disabled or no flash is active.
- WATCH: the supply is above the down line and no action is pending.
- FILT: a sag was seen and the filter delay is running.
- CUT: the filter delay expired and the policy action is applied.
- RISE: the up-and-down policy is raising the ceiling back to the target.
- FROZEN: the stop-and-hold policy has frozen the level.

Its transitions are:
- start: IDLE→WATCH, when enabled with a flash active.
- sag: WATCH or RISE→FILT, when the supply is below the down line; this fires the flag.
- recover: FILT→WATCH, when the supply is back at or above the down line before the delay expires.
- expire: FILT→CUT, or FILT→FROZEN under the hold policy.
- lift: CUT→RISE under the up-and-down policy, or CUT→WATCH otherwise, when the supply reaches the up line.
- settle: RISE→WATCH, when the ceiling reaches the target.
- abort: any state→IDLE, when the block is disabled or the flash ends.

Top module: `vin_flash_governor`

## Requirements
- R1: The down line is 2900 mV + 100 mV × `dn_sel` (3-bit). A sample strictly below the down line counts as a sag; a sample equal to it does not.
- R2: The up line is the down line plus the hysteresis from `hyst_sel`: 00 = 50 mV, 01 = 100 mV, 10 = 150 mV, 11 = 0 mV. The CUT state is left only when the sample is at or above the up line.
- R3: With `mode_sel` = 00 (report), the sag flag still fires, but the level is never changed and no decrement or increment strobe is issued.
- R4: With `mode_sel` = 01 (hold), at filter expiry the level is frozen at the value it had. `hold_o` stays high and the level stays constant until the flash ends, even if the ramp level keeps rising or the supply recovers.
- R5: With `mode_sel` = 10 (down only), in CUT each `step_tick` lowers the level by one step with a `dec_o` strobe, saturating at 0. After the supply recovers, the level is never raised before the next flash. A later sag cuts again.
- R6: With `mode_sel` = 11 (up and down), in RISE each `step_tick` raises the ceiling by one with an `inc_o` strobe, until it equals `tgt_lvl`.
- R7: The filter delay lasts, in clock cycles, HALF_STEP_CYC for `filt_sel` 00, T256_CYC for 01, 2×T256_CYC for 10 and 4×T256_CYC for 11. With `step_tick` held high, the first `dec_o` follows the flag by delay + 1 cycles.
- R8: A sample at or above the down line during the filter delay cancels the pending action. The next sag flags again and restarts the delay from zero.
- R9: `flag_o` is a one-cycle pulse issued on each transition into a sag from WATCH or RISE.
- R10: While `gov_en` is low or `flash_on` is low, `level_o` equals `ramp_lvl`, and `flag_o`, `dec_o`, `inc_o` and `hold_o` are all low.
- R11: Each new flash starts with the ceiling restored to `tgt_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gov_en | input | 1 | Function enable (reset value of the controlling bit is 0) |
| flash_on | input | 1 | High for the duration of a flash pulse |
| vin_mv | input | VW (13) | Supply sample in millivolts |
| dn_sel | input | 3 | Down-line code |
| hyst_sel | input | 2 | Hysteresis code |
| mode_sel | input | 2 | Policy: 00 report, 01 hold, 10 down only, 11 up and down |
| filt_sel | input | 2 | Filter delay code |
| ramp_lvl | input | LW (4) | Current level from the ramp controller |
| tgt_lvl | input | LW (4) | Programmed flash target level |
| step_tick | input | 1 | One pulse per ramp step period |
| level_o | output | LW (4) | Governed current level |
| hold_o | output | 1 | Ramp must hold its level |
| dec_o | output | 1 | One-cycle strobe: level stepped down |
| inc_o | output | 1 | One-cycle strobe: level stepped up |
| flag_o | output | 1 | One-cycle strobe: down line crossed |

## Verification
The assertions take for granted that `ramp_lvl` never falls and `tgt_lvl` does not change while a flash is active. They also take for granted that the threshold, hysteresis and policy codes change only between flashes. Under those conditions a decrement must lower the level and a frozen level must stay put. The stimulus follows this: ramp and target are moved only while `flash_on` is low, apart from an upward ramp step during the hold test. The supply sample is changed a cycle after the clock edge so that each crossing is seen at one defined edge.

// File: rtl/gov_pkg.sv
`timescale 1ns/1ps
package gov_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WATCH,
        ST_FILT,
        ST_CUT,
        ST_RISE,
        ST_FROZEN
    } gov_state_t;

    localparam logic [1:0] POL_REPORT = 2'b00;
    localparam logic [1:0] POL_HOLD   = 2'b01;
    localparam logic [1:0] POL_DOWN   = 2'b10;
    localparam logic [1:0] POL_UPDN   = 2'b11;
endpackage

// File: rtl/gov_thresh.sv
`timescale 1ns/1ps
module gov_thresh #(
    parameter int VW           = 13,
    parameter int BASE_MV      = 2900,
    parameter int STEP_MV      = 100,
    parameter int HYST_STEP_MV = 50
) (
    input  logic [VW-1:0] vin_mv,
    input  logic [2:0]    dn_sel,
    input  logic [1:0]    hyst_sel,
    output logic          below_dn,
    output logic          reach_up
);
    logic [VW-1:0] dn_mv;
    logic [VW-1:0] hyst_mv;
    logic [VW-1:0] up_mv;

    always_comb begin
        dn_mv = VW'(BASE_MV) + VW'(STEP_MV) * VW'(dn_sel);
        unique case (hyst_sel)
            2'b00:   hyst_mv = VW'(HYST_STEP_MV);
            2'b01:   hyst_mv = VW'(2 * HYST_STEP_MV);
            2'b10:   hyst_mv = VW'(3 * HYST_STEP_MV);
            default: hyst_mv = '0;
        endcase
        up_mv    = dn_mv + hyst_mv;
        below_dn = (vin_mv < dn_mv);
        reach_up = (vin_mv >= up_mv);
    end
endmodule

// File: rtl/gov_filter.sv
`timescale 1ns/1ps
module gov_filter #(
    parameter int HALF_STEP_CYC = 3,
    parameter int T256_CYC      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] filt_sel,
    output logic       expired
);
    localparam int MAXL = (HALF_STEP_CYC > 4 * T256_CYC) ? HALF_STEP_CYC : 4 * T256_CYC;
    localparam int CW   = $clog2(MAXL + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        unique case (filt_sel)
            2'b00:   lim = CW'(HALF_STEP_CYC);
            2'b01:   lim = CW'(T256_CYC);
            2'b10:   lim = CW'(2 * T256_CYC);
            default: lim = CW'(4 * T256_CYC);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (!run) cnt <= '0;
        else if (cnt != lim - CW'(1)) cnt <= cnt + CW'(1);
    end

    assign expired = run && (cnt == lim - CW'(1));

    // R7: the window counter never passes the selected delay
    p_filter_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < lim))
        else $error("filter counter beyond selected delay");
endmodule

// File: rtl/vin_flash_governor.sv
`timescale 1ns/1ps
module vin_flash_governor
    import gov_pkg::*;
#(
    parameter int VW            = 13,
    parameter int LW            = 4,
    parameter int HALF_STEP_CYC = 3,
    parameter int T256_CYC      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gov_en,
    input  logic          flash_on,
    input  logic [VW-1:0] vin_mv,
    input  logic [2:0]    dn_sel,
    input  logic [1:0]    hyst_sel,
    input  logic [1:0]    mode_sel,
    input  logic [1:0]    filt_sel,
    input  logic [LW-1:0] ramp_lvl,
    input  logic [LW-1:0] tgt_lvl,
    input  logic          step_tick,
    output logic [LW-1:0] level_o,
    output logic          hold_o,
    output logic          dec_o,
    output logic          inc_o,
    output logic          flag_o
);
    localparam logic [LW-1:0] ONE = LW'(1);

    gov_state_t    st, nxt;
    logic          below_dn, reach_up, filt_done;
    logic [LW-1:0] cap_q;
    logic [LW-1:0] lvl;

    gov_thresh #(.VW(VW)) u_thresh (
        .vin_mv   (vin_mv),
        .dn_sel   (dn_sel),
        .hyst_sel (hyst_sel),
        .below_dn (below_dn),
        .reach_up (reach_up)
    );

    gov_filter #(.HALF_STEP_CYC(HALF_STEP_CYC), .T256_CYC(T256_CYC)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st == ST_FILT),
        .filt_sel (filt_sel),
        .expired  (filt_done)
    );

    assign lvl = (st == ST_IDLE) ? ramp_lvl : ((ramp_lvl < cap_q) ? ramp_lvl : cap_q);

    // next-state decision
    always_comb begin
        nxt = st;
        if (!gov_en || !flash_on) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:   nxt = ST_WATCH;
                ST_WATCH: begin
                    if (below_dn)
                        nxt = ST_FILT;
                    else if (mode_sel == POL_UPDN && reach_up && cap_q < tgt_lvl)
                        nxt = ST_RISE;
                end
                ST_FILT: begin
                    if (!below_dn)
                        nxt = ST_WATCH;
                    else if (filt_done)
                        nxt = (mode_sel == POL_HOLD) ? ST_FROZEN : ST_CUT;
                end
                ST_CUT: begin
                    if (reach_up)
                        nxt = (mode_sel == POL_UPDN && cap_q < tgt_lvl) ? ST_RISE : ST_WATCH;
                end
                ST_RISE: begin
                    if (below_dn)
                        nxt = ST_FILT;
                    else if (cap_q >= tgt_lvl)
                        nxt = ST_WATCH;
                end
                ST_FROZEN: nxt = ST_FROZEN;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // ceiling and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q  <= '0;
            flag_o <= 1'b0;
            dec_o  <= 1'b0;
            inc_o  <= 1'b0;
        end else begin
            flag_o <= (nxt == ST_FILT) && (st == ST_WATCH || st == ST_RISE);
            dec_o  <= 1'b0;
            inc_o  <= 1'b0;
            if (st == ST_IDLE) begin
                cap_q <= tgt_lvl;
            end else if (st == ST_FILT && nxt == ST_FROZEN) begin
                cap_q <= lvl;
            end else if (st == ST_CUT && nxt == ST_CUT && step_tick && mode_sel[1]) begin
                if (lvl != '0) begin
                    cap_q <= lvl - ONE;
                    dec_o <= 1'b1;
                end
            end else if (st == ST_RISE && nxt == ST_RISE && step_tick &&
                         mode_sel == POL_UPDN && cap_q < tgt_lvl) begin
                cap_q <= cap_q + ONE;
                inc_o <= 1'b1;
            end
        end
    end

    assign level_o = lvl;
    assign hold_o  = (st == ST_FROZEN);

    // R10: no strobes once the function is switched off
    p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !gov_en |=> (!flag_o && !dec_o && !inc_o))
        else $error("strobe while disabled");

    // R3: report policy never touches the level
    p_report_no_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == POL_REPORT) |=> (!dec_o && !inc_o))
        else $error("level changed under report policy");

    // R5: down-only policy never raises
    p_down_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == POL_DOWN) |=> !inc_o)
        else $error("raise under down-only policy");

    // R5: a decrement strobe comes with a lower level
    p_cut_lowers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_o |-> (level_o < $past(level_o)))
        else $error("decrement without lower level");

    // R4: frozen level does not move
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && $past(hold_o)) |-> $stable(level_o))
        else $error("level moved while frozen");

    // R9: flag lasts a single cycle
    p_flag_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |=> !flag_o)
        else $error("flag longer than one cycle");
endmodule

// File: tb/tb_vin_flash_governor.sv
`timescale 1ns/1ps
module tb_vin_flash_governor;
    localparam int VW = 13;
    localparam int LW = 4;
    localparam int HALF = 3;
    localparam int T256 = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gov_en = 1'b0;
    logic          flash_on = 1'b0;
    logic [VW-1:0] vin_mv = 13'd3500;
    logic [2:0]    dn_sel = 3'd2;
    logic [1:0]    hyst_sel = 2'b00;
    logic [1:0]    mode_sel = 2'b00;
    logic [1:0]    filt_sel = 2'b00;
    logic [LW-1:0] ramp_lvl = 4'd10;
    logic [LW-1:0] tgt_lvl = 4'd10;
    logic          step_tick = 1'b0;
    logic [LW-1:0] level_o;
    logic          hold_o, dec_o, inc_o, flag_o;

    always #2.5 clk = ~clk;

    vin_flash_governor #(.VW(VW), .LW(LW), .HALF_STEP_CYC(HALF), .T256_CYC(T256)) dut (
        .clk(clk), .rst_n(rst_n), .gov_en(gov_en), .flash_on(flash_on),
        .vin_mv(vin_mv), .dn_sel(dn_sel), .hyst_sel(hyst_sel), .mode_sel(mode_sel),
        .filt_sel(filt_sel), .ramp_lvl(ramp_lvl), .tgt_lvl(tgt_lvl), .step_tick(step_tick),
        .level_o(level_o), .hold_o(hold_o), .dec_o(dec_o), .inc_o(inc_o), .flag_o(flag_o)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    t_flag = 0;
    int    t_dec = 0;
    bit    arm_dec = 0;
    int    kind_q[$];
    int    lvl_q[$];
    string req_q[$];

    localparam int EV_FLAG = 1;
    localparam int EV_DEC  = 2;
    localparam int EV_INC  = 3;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int lvl, input string req);
        kind_q.push_back(kind);
        lvl_q.push_back(lvl);
        req_q.push_back(req);
    endtask

    // monitor: compare strobes against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && (flag_o || dec_o || inc_o)) begin
            int k;
            k = flag_o ? EV_FLAG : (dec_o ? EV_DEC : EV_INC);
            if (flag_o) t_flag = cyc;
            if (dec_o && arm_dec) begin
                t_dec = cyc;
                arm_dec = 0;
            end
            if (kind_q.size() == 0) begin
                chk(0, "unexpected strobe", k, 0);
            end else begin
                int ek, el;
                string er;
                ek = kind_q.pop_front();
                el = lvl_q.pop_front();
                er = req_q.pop_front();
                chk(k == ek, er, k, ek);
                chk(int'(level_o) == el, er, level_o, el);
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            step_tick = 1'b1;
            wt(1);
            step_tick = 1'b0;
            wt(3);
        end
    endtask

    task automatic new_flash();
        flash_on = 1'b0;
        wt(3);
        flash_on = 1'b1;
        wt(3);
    endtask

    initial begin
        wt(3);
        rst_n = 1'b1;
        wt(2);
        // reset state
        chk(level_o == 4'd10, "R10 reset level", level_o, 10);
        chk(!hold_o && !flag_o && !dec_o && !inc_o, "R10 reset strobes", hold_o, 0);

        // R10: disabled, flash active, supply sagging
        flash_on = 1'b1;
        vin_mv = 13'd2500;
        mode_sel = 2'b10;
        wt(30);
        chk(level_o == 4'd10, "R10 disabled level", level_o, 10);
        chk(!hold_o, "R10 disabled hold", hold_o, 0);
        flash_on = 1'b0;
        vin_mv = 13'd3500;
        wt(3);

        // R1 / R3 / R9: report policy, boundary at 3100 mV
        gov_en = 1'b1;
        mode_sel = 2'b00;
        new_flash();
        vin_mv = 13'd3100;
        wt(20);
        chk(level_o == 4'd10, "R1 equal to down line", level_o, 10);
        expect_ev(EV_FLAG, 10, "R1 sag flag");
        vin_mv = 13'd3099;
        wt(20);
        tick_n(2);
        chk(level_o == 4'd10, "R3 report keeps level", level_o, 10);
        vin_mv = 13'd3150;
        wt(3);
        expect_ev(EV_FLAG, 10, "R9 second crossing");
        vin_mv = 13'd3099;
        wt(10);
        vin_mv = 13'd3500;
        flash_on = 1'b0;
        wt(3);

        // R7 / R5: filter delays with step_tick held high, saturation at 0
        mode_sel = 2'b10;
        for (int c = 0; c < 4; c++) begin
            int lim;
            lim = (c == 0) ? HALF : (c == 1) ? T256 : (c == 2) ? 2 * T256 : 4 * T256;
            filt_sel = 2'(c);
            new_flash();
            expect_ev(EV_FLAG, 10, "R7 flag");
            for (int l = 9; l >= 0; l--) expect_ev(EV_DEC, l, "R5 cut step");
            step_tick = 1'b1;
            arm_dec = 1;
            vin_mv = 13'd3000;
            wt(60);
            chk((t_dec - t_flag) == lim + 1, "R7 filter delay", t_dec - t_flag, lim + 1);
            chk(level_o == 4'd0, "R5 saturates at 0", level_o, 0);
            step_tick = 1'b0;
            vin_mv = 13'd3500;
            flash_on = 1'b0;
            wt(3);
        end

        // R8 / R5 / R11: cancel, repeated cut, no rise, restore on new flash
        filt_sel = 2'b11;
        new_flash();
        expect_ev(EV_FLAG, 10, "R8 first sag");
        vin_mv = 13'd3000;
        wt(10);
        vin_mv = 13'd3120;
        wt(40);
        chk(level_o == 4'd10, "R8 cancelled cut", level_o, 10);
        expect_ev(EV_FLAG, 10, "R8 re-flag");
        vin_mv = 13'd3000;
        wt(40);
        expect_ev(EV_DEC, 9, "R5 dec");
        expect_ev(EV_DEC, 8, "R5 dec");
        expect_ev(EV_DEC, 7, "R5 dec");
        tick_n(3);
        vin_mv = 13'd3200;
        wt(3);
        tick_n(3);
        chk(level_o == 4'd7, "R5 no rise after recovery", level_o, 7);
        expect_ev(EV_FLAG, 7, "R5 later sag");
        vin_mv = 13'd3000;
        wt(40);
        expect_ev(EV_DEC, 6, "R5 dec again");
        expect_ev(EV_DEC, 5, "R5 dec again");
        tick_n(2);
        chk(level_o == 4'd5, "R5 level after second cut", level_o, 5);
        vin_mv = 13'd3500;
        new_flash();
        chk(level_o == 4'd10, "R11 ceiling restored", level_o, 10);
        flash_on = 1'b0;
        wt(3);

        // R4: hold policy with a ramp still rising
        mode_sel = 2'b01;
        filt_sel = 2'b00;
        ramp_lvl = 4'd4;
        tgt_lvl = 4'd12;
        new_flash();
        expect_ev(EV_FLAG, 4, "R4 sag flag");
        vin_mv = 13'd3000;
        wt(15);
        chk(hold_o == 1'b1, "R4 hold asserted", hold_o, 1);
        ramp_lvl = 4'd8;
        wt(3);
        chk(level_o == 4'd4, "R4 frozen level", level_o, 4);
        vin_mv = 13'd3500;
        wt(5);
        chk(level_o == 4'd4 && hold_o, "R4 frozen after recovery", level_o, 4);
        flash_on = 1'b0;
        wt(2);
        chk(!hold_o, "R4 hold released", hold_o, 0);
        chk(level_o == 4'd8, "R10 pass-through after flash", level_o, 8);
        ramp_lvl = 4'd10;
        tgt_lvl = 4'd10;
        wt(2);

        // R6 / R2: up-and-down, 150 mV hysteresis
        mode_sel = 2'b11;
        hyst_sel = 2'b10;
        new_flash();
        expect_ev(EV_FLAG, 10, "R6 sag flag");
        vin_mv = 13'd3000;
        wt(10);
        for (int l = 9; l >= 6; l--) expect_ev(EV_DEC, l, "R6 cut");
        tick_n(4);
        vin_mv = 13'd3240;
        expect_ev(EV_DEC, 5, "R2 below up line keeps cutting");
        expect_ev(EV_DEC, 4, "R2 below up line keeps cutting");
        tick_n(2);
        vin_mv = 13'd3250;
        wt(2);
        for (int l = 5; l <= 10; l++) expect_ev(EV_INC, l, "R6 raise");
        tick_n(7);
        chk(level_o == 4'd10, "R6 stops at target", level_o, 10);
        vin_mv = 13'd3500;
        flash_on = 1'b0;
        wt(3);

        // R2 / R1: no hysteresis, down line at 2900 mV
        hyst_sel = 2'b11;
        dn_sel = 3'd0;
        new_flash();
        expect_ev(EV_FLAG, 10, "R1 code 0 sag");
        vin_mv = 13'd2899;
        wt(10);
        expect_ev(EV_DEC, 9, "R2 cut");
        tick_n(1);
        vin_mv = 13'd2900;
        wt(2);
        expect_ev(EV_INC, 10, "R2 zero hysteresis rise");
        tick_n(1);
        chk(level_o == 4'd10, "R2 zero hysteresis level", level_o, 10);
        flash_on = 1'b0;
        wt(5);

        chk(kind_q.size() == 0, "R9 all expected strobes seen", kind_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule